// File: doc/BRIEF.md
# Receive Pattern Synchronizer and Bit Error Detector

This block forms the receive half of a bit-error-rate tester. On each receive clock edge where receive-disable is low it accepts one serial NRZ bit. That bit comes from the external data input, or from the transmitted stream when loopback is selected, and it can be complemented first. A local reference register is configured like the transmitter: the same mode, length field, tap field and pattern. The block locks this reference to the incoming bits, declares and drops sync, and flags every accepted bit that disagrees with the reference while it is locked.

During a search, the reference register is loaded directly from the received bits, so it seeds itself. Once sync is declared, it free-runs on its own predictions. A loss of sync is detected over a sliding window of 64 in-sync bits; it can be disabled, and a resync strobe restarts the search at any time. Run detectors flag long strings of ones or zeros. A load strobe captures a 32-bit snapshot of the reference register for the host.

Top module: `bert_rx_sync`

## Requirements
- R1: In pseudorandom mode (`prbs_mode_i`=1) the predicted bit is `ref[len_i] ^ ref[tap_i]`, where `ref[0]` is the newest bit shifted in. With n = `len_i`+1, a search first loads n accepted bits without comparing them. After 34+n further consecutive matching accepted bits, `sync_o` goes high right after the edge of the last of those bits. A mismatch during the search restarts the match count.
- R2: In repetitive mode (`prbs_mode_i`=0) each accepted bit is compared with the bit accepted `len_i`+1 positions earlier. The fill and lock counts are the same as in R1.
- R3: While in sync, the reference shifts in its own predicted bit. Each accepted bit raises `bit_vld_o` for one cycle after its edge. If the bit differs from the prediction, `err_o` is also raised for that cycle.
- R4: While in sync with `auto_off_i`=0, `sync_o` drops right after the edge of the accepted bit that brings the count of errors among the last 64 in-sync bits to 6 or more. Five errors within that window keep sync.
- R5: With `auto_off_i`=1, errors never drop sync. They are still reported on `err_o`.
- R6: A rising edge of `resync_i` forces `sync_o` low after that edge and starts a new search from the fill phase.
- R7: When `rx_dis_i` is high at an edge, no bit is accepted. `bit_vld_o` is low in the next cycle, and the lock progress, loss window, reference and run counters are unchanged.
- R8: With `inv_i`=1 each selected bit is complemented before any comparison, run detection or storage.
- R9: With `lpbk_i`=1 the checked bit is taken from `tx_data_i` and `rx_data_i` is ignored.
- R10: `all_ones_o` is high once the last 32 accepted bits are all 1 and clears after the next accepted 0. `all_zeros_o` behaves the same way for 0s.
- R11: A rising edge of `snap_load_i` copies the reference register into `snap_o`. Out of sync this holds the last 32 accepted bits, with bit 0 the newest. In sync it holds 32 consecutive bits of the locked pattern, which is a rotation of it.
- R12: After reset, `sync_o`, `err_o`, `bit_vld_o`, `all_ones_o`, `all_zeros_o` are low and `snap_o` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rx_data_i | input | 1 | Serial received data |
| rx_dis_i | input | 1 | High: skip the bit at this edge |
| tx_data_i | input | 1 | Transmitted stream for loopback |
| lpbk_i | input | 1 | Check `tx_data_i` instead of `rx_data_i` |
| inv_i | input | 1 | Complement the received bits |
| prbs_mode_i | input | 1 | 1 pseudorandom, 0 repetitive |
| len_i | input | 5 | Pattern length minus one (tap A index) |
| tap_i | input | 5 | Second feedback index (tap B) |
| auto_off_i | input | 1 | 1 disables automatic loss of sync |
| resync_i | input | 1 | Rising edge restarts the search |
| snap_load_i | input | 1 | Rising edge captures the snapshot |
| sync_o | output | 1 | Real-time sync flag |
| err_o | output | 1 | One-cycle pulse for each errored bit in sync |
| bit_vld_o | output | 1 | One-cycle pulse for each accepted bit in sync |
| all_ones_o | output | 1 | 32 consecutive ones seen |
| all_zeros_o | output | 1 | 32 consecutive zeros seen |
| snap_o | output | 32 | Captured reference snapshot |

## Verification
Every result is registered once, so `sync_o`, `err_o`, `bit_vld_o`, the run flags and `snap_o` all reflect the bit or strobe presented at an edge just after that same edge. Inputs change on the falling edge, and outputs are sampled 1 ns after the rising edge that took the bit. Each check therefore names the exact bit whose edge should change the output. Lock timing is checked at bit 34+2n−1 (still out of sync) and at bit 34+2n (in sync). Loss of sync is checked on the fifth error (still in sync) and on the sixth (sync lost). Strobes are applied with receive-disable high, so no bit is accepted in the same cycle.

// File: rtl/bert_rx_pkg.sv
package bert_rx_pkg;
  localparam int DEF_REF_W     = 32;
  localparam int DEF_WIN_LEN   = 64;
  localparam int DEF_LOSS_THR  = 6;
  localparam int DEF_LOCK_BASE = 34;
  localparam int DEF_RUN_LEN   = 32;
endpackage

// File: rtl/bert_ref_gen.sv
module bert_ref_gen #(
  parameter int REF_W = 32,
  parameter int LEN_W = $clog2(REF_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             acc_i,
  input  logic             bit_i,
  input  logic             track_i,
  input  logic             prbs_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] tap_i,
  output logic             pred_o,
  output logic [REF_W-1:0] ref_o
);
  logic [REF_W-1:0] ref_q;

  assign pred_o = prbs_i ? (ref_q[len_i] ^ ref_q[tap_i]) : ref_q[len_i];
  assign ref_o  = ref_q;

  // search: self-seed from line; sync: free-run on prediction
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    ref_q <= '0;
    else if (acc_i) ref_q <= {ref_q[REF_W-2:0], track_i ? pred_o : bit_i};
  end

  // R7
  ref_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_i |=> $stable(ref_q));
endmodule

// File: rtl/bert_loss_window.sv
module bert_loss_window #(
  parameter int WIN_LEN = 64,
  parameter int CNT_W   = $clog2(WIN_LEN + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             shift_i,
  input  logic             err_i,
  output logic [CNT_W-1:0] cnt_nxt_o
);
  logic [WIN_LEN-1:0] win_q;
  logic [CNT_W-1:0]   cnt_q;

  assign cnt_nxt_o = shift_i ? cnt_q + CNT_W'(err_i) - CNT_W'(win_q[WIN_LEN-1]) : cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (clr_i) begin
      win_q <= '0;
      cnt_q <= '0;
    end else if (shift_i) begin
      win_q <= {win_q[WIN_LEN-2:0], err_i};
      cnt_q <= cnt_nxt_o;
    end
  end

  // R4
  win_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q == CNT_W'($countones(win_q)));
endmodule

// File: rtl/bert_run_detect.sv
module bert_run_detect #(
  parameter int   RUN_LEN = 32,
  parameter logic POL     = 1'b1,
  parameter int   CNT_W   = $clog2(RUN_LEN + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic acc_i,
  input  logic bit_i,
  output logic flag_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (acc_i) begin
      if (bit_i != POL)                 cnt_q <= '0;
      else if (cnt_q != CNT_W'(RUN_LEN)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign flag_o = (cnt_q == CNT_W'(RUN_LEN));

  // R10
  run_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_o) |-> $past(acc_i && (bit_i == POL)));
endmodule

// File: rtl/bert_rx_sync.sv
module bert_rx_sync
  import bert_rx_pkg::*;
#(
  parameter int REF_W     = DEF_REF_W,
  parameter int WIN_LEN   = DEF_WIN_LEN,
  parameter int LOSS_THR  = DEF_LOSS_THR,
  parameter int LOCK_BASE = DEF_LOCK_BASE,
  parameter int RUN_LEN   = DEF_RUN_LEN,
  parameter int LEN_W     = $clog2(REF_W)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rx_data_i,
  input  logic             rx_dis_i,
  input  logic             tx_data_i,
  input  logic             lpbk_i,
  input  logic             inv_i,
  input  logic             prbs_mode_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [LEN_W-1:0] tap_i,
  input  logic             auto_off_i,
  input  logic             resync_i,
  input  logic             snap_load_i,
  output logic             sync_o,
  output logic             err_o,
  output logic             bit_vld_o,
  output logic             all_ones_o,
  output logic             all_zeros_o,
  output logic [REF_W-1:0] snap_o
);
  localparam int MATCH_W = $clog2(LOCK_BASE + REF_W + 1);
  localparam int WCNT_W  = $clog2(WIN_LEN + 1);

  logic             sync_q, err_q, vld_q;
  logic             resync_prev_q, snap_prev_q;
  logic [LEN_W:0]   fill_q;
  logic [MATCH_W-1:0] match_q;
  logic [REF_W-1:0] snap_q, ref_w;
  logic [WCNT_W-1:0] loss_cnt;
  logic [1:0]       run_flag;

  logic bit_acc, bit_in, pred, mismatch, resync_edge, snap_edge, drop, fill_done;
  logic [LEN_W:0]     n_len;
  logic [MATCH_W-1:0] lock_thr, match_inc;

  assign bit_acc     = ~rx_dis_i;
  assign bit_in      = (lpbk_i ? tx_data_i : rx_data_i) ^ inv_i;
  assign resync_edge = resync_i & ~resync_prev_q;
  assign snap_edge   = snap_load_i & ~snap_prev_q;
  assign mismatch    = bit_in ^ pred;
  assign n_len       = {1'b0, len_i} + 1'b1;
  assign fill_done   = (fill_q == n_len);
  assign lock_thr    = MATCH_W'(LOCK_BASE) + MATCH_W'(n_len);
  assign match_inc   = match_q + 1'b1;
  assign drop        = ~auto_off_i & (loss_cnt >= WCNT_W'(LOSS_THR));

  bert_ref_gen #(.REF_W(REF_W), .LEN_W(LEN_W)) u_ref (
    .clk_i, .rst_ni,
    .acc_i   (bit_acc),
    .bit_i   (bit_in),
    .track_i (sync_q),
    .prbs_i  (prbs_mode_i),
    .len_i, .tap_i,
    .pred_o  (pred),
    .ref_o   (ref_w)
  );

  bert_loss_window #(.WIN_LEN(WIN_LEN), .CNT_W(WCNT_W)) u_win (
    .clk_i, .rst_ni,
    .clr_i     (resync_edge | ~sync_q),
    .shift_i   (bit_acc & sync_q),
    .err_i     (mismatch),
    .cnt_nxt_o (loss_cnt)
  );

  for (genvar g = 0; g < 2; g++) begin : g_run
    bert_run_detect #(.RUN_LEN(RUN_LEN), .POL(1'(g))) u_run (
      .clk_i, .rst_ni,
      .acc_i  (bit_acc),
      .bit_i  (bit_in),
      .flag_o (run_flag[g])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q        <= 1'b0;
      fill_q        <= '0;
      match_q       <= '0;
      err_q         <= 1'b0;
      vld_q         <= 1'b0;
      resync_prev_q <= 1'b0;
      snap_prev_q   <= 1'b0;
      snap_q        <= '0;
    end else begin
      resync_prev_q <= resync_i;
      snap_prev_q   <= snap_load_i;
      err_q         <= bit_acc & sync_q & mismatch;
      vld_q         <= bit_acc & sync_q;
      if (snap_edge) snap_q <= ref_w;
      if (resync_edge) begin
        sync_q  <= 1'b0;
        fill_q  <= '0;
        match_q <= '0;
      end else if (bit_acc) begin
        if (sync_q) begin
          if (drop) begin
            sync_q  <= 1'b0;
            fill_q  <= '0;
            match_q <= '0;
          end
        end else if (!fill_done) begin
          fill_q <= fill_q + 1'b1;
        end else if (mismatch) begin
          match_q <= '0;
        end else if (match_inc >= lock_thr) begin
          sync_q  <= 1'b1;
          match_q <= '0;
        end else begin
          match_q <= match_inc;
        end
      end
    end
  end

  assign sync_o      = sync_q;
  assign err_o       = err_q;
  assign bit_vld_o   = vld_q;
  assign all_zeros_o = run_flag[0];
  assign all_ones_o  = run_flag[1];
  assign snap_o      = snap_q;

  // R1
  lock_on_bit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sync_q && !bit_acc) |=> !sync_q);
  // R3
  err_in_sync_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_q |-> vld_q);
  // R5
  no_auto_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sync_q && auto_off_i && !resync_edge) |=> sync_q);
  // R6
  resync_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resync_edge |=> !sync_q);
  // R7
  dis_no_vld_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_dis_i |=> !vld_q);
endmodule

// File: tb/bert_rx_sync_bench.sv
module bert_rx_sync_bench;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic rx_data_i = 0, rx_dis_i = 1, tx_data_i = 0, lpbk_i = 0, inv_i = 0;
  logic prbs_mode_i = 1, auto_off_i = 0, resync_i = 0, snap_load_i = 0;
  logic [4:0] len_i = 5'd6, tap_i = 5'd5;
  logic sync_o, err_o, bit_vld_o, all_ones_o, all_zeros_o;
  logic [31:0] snap_o;

  always #10 clk_i = ~clk_i;

  bert_rx_sync u_bert_rx_sync (
    .clk_i, .rst_ni, .rx_data_i, .rx_dis_i, .tx_data_i, .lpbk_i, .inv_i,
    .prbs_mode_i, .len_i, .tap_i, .auto_off_i, .resync_i, .snap_load_i,
    .sync_o, .err_o, .bit_vld_o, .all_ones_o, .all_zeros_o, .snap_o
  );

  int n_chk = 0, n_fail = 0, idle_bad = 0, err_sum = 0, pidx = 0;
  logic [31:0] gen_s = 32'h5A5A_1234, last32 = '0;
  logic [7:0] pat = 8'h26;
  logic lb = 0, tx_inv = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input logic b, input logic dis);
    @(negedge clk_i);
    rx_dis_i = dis;
    if (lb) begin tx_data_i = b; rx_data_i = 1'($urandom); end
    else    begin rx_data_i = b; tx_data_i = 1'($urandom); end
    @(posedge clk_i); #1;
    if (dis && bit_vld_o) idle_bad++;
    if (!dis) begin
      last32 = {last32[30:0], b};
      err_sum += int'(err_o);
    end
  endtask

  task automatic gen_bit(output logic b);
    if (prbs_mode_i) begin
      b = gen_s[len_i] ^ gen_s[tap_i];
      gen_s = {gen_s[30:0], b};
    end else begin
      b = pat[7-pidx];
      pidx = (pidx + 1) % 8;
    end
  endtask

  task automatic send(input int cnt, input logic flip_last);
    for (int i = 0; i < cnt; i++) begin
      logic b;
      if (($urandom % 4) == 0) step(1'($urandom), 1'b1);
      gen_bit(b);
      step(b ^ tx_inv ^ (flip_last && (i == cnt - 1)), 1'b0);
    end
  endtask

  task automatic pulse_resync();
    @(negedge clk_i); resync_i = 1; rx_dis_i = 1;
    @(posedge clk_i); #1;
    @(negedge clk_i); resync_i = 0;
    @(posedge clk_i); #1;
  endtask

  task automatic pulse_snap();
    @(negedge clk_i); snap_load_i = 1; rx_dis_i = 1;
    @(posedge clk_i); #1;
    @(negedge clk_i); snap_load_i = 0;
    @(posedge clk_i); #1;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic ok;
    logic [31:0] rep;
    void'($urandom(32'd7));
    repeat (3) @(posedge clk_i);
    @(negedge clk_i) rst_ni = 1;
    @(posedge clk_i); #1;
    // R12 reset state
    chk("R12 sync", 32'(sync_o), 0);
    chk("R12 err", 32'(err_o), 0);
    chk("R12 vld", 32'(bit_vld_o), 0);
    chk("R12 runs", {30'd0, all_ones_o, all_zeros_o}, 0);
    chk("R12 snap", snap_o, 0);

    // R1 pseudorandom lock: 7 fill + 41 matches = 48 bits
    pulse_resync();
    send(47, 0);
    chk("R1 before lock", 32'(sync_o), 0);
    send(1, 0);
    chk("R1 lock", 32'(sync_o), 1);

    // R3 clean stream, then single error
    err_sum = 0;
    send(300, 0);
    chk("R3 clean errors", 32'(err_sum), 0);
    send(1, 1);
    chk("R3 err pulse", 32'(err_o), 1);
    chk("R3 vld pulse", 32'(bit_vld_o), 1);
    send(1, 0);
    chk("R3 err clears", 32'(err_o), 0);

    // R4 loss window
    send(70, 0);
    for (int k = 0; k < 5; k++) begin send(6, 0); send(1, 1); end
    chk("R4 five errors keep sync", 32'(sync_o), 1);
    send(6, 0); send(1, 1);
    chk("R4 sixth error drops", 32'(sync_o), 0);
    chk("R4 sixth error flagged", 32'(err_o), 1);
    chk("R7 idle no vld", 32'(idle_bad), 0);

    // R5 auto resync off
    auto_off_i = 1;
    pulse_resync();
    send(48, 0);
    chk("R5 lock", 32'(sync_o), 1);
    err_sum = 0;
    repeat (10) begin send(2, 0); send(1, 1); end
    chk("R5 errors seen", 32'(err_sum), 10);
    chk("R5 sync held", 32'(sync_o), 1);
    auto_off_i = 0;

    // R6 manual resync
    pulse_resync();
    chk("R6 resync drops", 32'(sync_o), 0);
    send(47, 0);
    chk("R6 new search", 32'(sync_o), 0);
    send(1, 0);
    chk("R6 relock", 32'(sync_o), 1);

    // R8 inversion
    inv_i = 1; tx_inv = 1;
    pulse_resync();
    send(48, 0);
    chk("R8 inverted lock", 32'(sync_o), 1);
    err_sum = 0;
    send(100, 0);
    chk("R8 inverted errors", 32'(err_sum), 0);
    inv_i = 0; tx_inv = 0;

    // R9 loopback, rx_data random
    lb = 1; lpbk_i = 1;
    pulse_resync();
    send(48, 0);
    chk("R9 loopback lock", 32'(sync_o), 1);
    err_sum = 0;
    send(200, 0);
    chk("R9 loopback errors", 32'(err_sum), 0);
    lb = 0; lpbk_i = 0;

    // R11 out-of-sync snapshot, repetitive mode
    prbs_mode_i = 0; len_i = 5'd7;
    pulse_resync();
    for (int i = 0; i < 40; i++) step(1'($urandom), 1'b0);
    pulse_snap();
    chk("R11 search sync", 32'(sync_o), 0);
    chk("R11 raw snapshot", snap_o, last32);

    // R2 repetitive lock: 8 fill + 42 matches = 50 bits
    pidx = 0;
    pulse_resync();
    send(49, 0);
    chk("R2 before lock", 32'(sync_o), 0);
    send(1, 0);
    chk("R2 lock", 32'(sync_o), 1);
    pulse_snap();
    rep = {4{pat}};
    ok = 0;
    for (int r = 0; r < 8; r++)
      if (snap_o == ((rep << r) | (rep >> (32 - r)))) ok = 1;
    chk("R11 locked rotation", 32'(ok), 1);
    send(1, 1);
    chk("R3 repetitive err", 32'(err_o), 1);

    // R10 run flags, R7 idle ignored
    pulse_resync();
    repeat (16) step(1'b1, 1'b0);
    step(1'b0, 1'b1);
    repeat (15) step(1'b1, 1'b0);
    chk("R10 ones at 31", 32'(all_ones_o), 0);
    step(1'b1, 1'b0);
    chk("R7 R10 ones at 32", 32'(all_ones_o), 1);
    chk("R10 zeros off", 32'(all_zeros_o), 0);
    step(1'b0, 1'b0);
    chk("R10 ones clear", 32'(all_ones_o), 0);
    repeat (30) step(1'b0, 1'b0);
    chk("R10 zeros at 31", 32'(all_zeros_o), 0);
    step(1'b0, 1'b0);
    chk("R10 zeros at 32", 32'(all_zeros_o), 1);
    step(1'b1, 1'b0);
    chk("R10 zeros clear", 32'(all_zeros_o), 0);

    finish_run();
  end
endmodule